// File: doc/BRIEF.md
# Secure Monitor Call Trap Router

This block decides what happens when a core executes a secure monitor call. The instruction decoder raises a one-cycle request strobe and presents the call context at the same time. The context is the current exception level, the security state, whether the top privilege level (level 3) is implemented, and the register width of that level. It also includes the monitor-call disable flag, the hypervisor trap-on-monitor-call control, whether the call arrives over the monitor-call conduit, and whether it is a valid firmware call. The block registers one of four outcomes with a target exception level. It also registers the syndrome to report, and raises a done pulse one cycle after the strobe.

The four outcomes are: trap to the hypervisor, undefined instruction, trap to the monitor, and firmware call. The exception entry logic and the firmware service code downstream act on the registered result. This block does neither the firmware work nor the vector computation.

The control is a two-state machine. `ST_IDLE` waits for a strobe, and the transition IDLE->RESP is taken on `req_i`. `ST_RESP` drives the done pulse for one cycle. From RESP, the transition RESP->RESP is taken when another strobe arrives in that cycle, and RESP->IDLE is taken otherwise.

Top module: `smc_route_top`

## Requirements
- R1: The disable flag is effective when `mon_dis_i`=1 and either `top_is64_i`=1 (both security states) or `secure_i`=0. With `top_is64_i`=0 and `secure_i`=1 the flag has no effect on the outcome.
- R2: When `top_present_i`=0 and `conduit_smc_i`=0, the outcome is undefined instruction, whatever the other inputs are.
- R3: Outside the R2 case, a request at level 1 with `hyp_tsc_i`=1 gives hypervisor trap. The target is 2 and `syndrome_o` equals the `syndrome_i` given with the request. This outranks the disable flag and firmware-call validity.
- R4: With no hypervisor trap, a request with `conduit_smc_i`=1 and `fw_call_ok_i`=1 gives firmware call with target 3, even when the disable flag is set.
- R5: With no hypervisor trap and no valid firmware call, the outcome is undefined instruction if the disable flag is effective or `top_present_i`=0.
- R6: The remaining case (level 3 present, disable flag not effective, no valid firmware call, no hypervisor trap) gives monitor trap with target 3.
- R7: An undefined-instruction outcome targets level 3 when `secure_i`=1 and `top_is64_i`=0, and level 1 otherwise. Every outcome other than hypervisor trap reports a syndrome of 0.
- R8: The outcome encoding is 0 for hypervisor trap, 1 for undefined instruction, 2 for monitor trap and 3 for firmware call. `done_o` is high for exactly the cycle after each strobe cycle. The outcome, target and syndrome hold their value until the next strobe.
- R9: During and after reset, `done_o`=0, `outcome_o`=1, `target_el_o`=0 and `syndrome_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | One-cycle request strobe |
| cur_el_i | input | 2 | Current exception level |
| secure_i | input | 1 | 1 = secure state |
| top_present_i | input | 1 | Level 3 implemented |
| mon_dis_i | input | 1 | Monitor-call disable flag |
| hyp_tsc_i | input | 1 | Hypervisor trap-on-monitor-call control |
| conduit_smc_i | input | 1 | Firmware calls use the monitor-call conduit |
| fw_call_ok_i | input | 1 | Call is a valid firmware call |
| top_is64_i | input | 1 | Level 3 runs in 64-bit state |
| syndrome_i | input | SYN_W | Syndrome supplied with the request |
| done_o | output | 1 | Result valid pulse |
| outcome_o | output | 2 | Registered outcome code |
| target_el_o | output | 2 | Registered target level |
| syndrome_o | output | SYN_W | Registered syndrome |

## Verification
The bench checks four interactions that a wrong design would get wrong.
- The disable flag in secure state with a 32-bit top level. A design that ignores the width dependence reports undefined instruction here instead of monitor trap.
- The hypervisor trap with the disable flag set and a valid firmware call. Wrong priority turns this into undefined instruction or firmware call.
- A missing top level together with a non-monitor conduit. A design that lets the hypervisor trap win here routes to level 2.
- A valid firmware call with the disable flag set. A design that applies the disable flag first reports undefined instruction.

Beyond these cases, the bench sweeps every input combination against a priority model. It also checks back-to-back strobes for one done pulse each, and checks that results hold while idle.

// File: rtl/smc_route_pkg.sv
package smc_route_pkg;

    typedef enum logic [1:0] {
        OUT_HYP   = 2'd0,
        OUT_UNDEF = 2'd1,
        OUT_MON   = 2'd2,
        OUT_FW    = 2'd3
    } smc_outcome_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } smc_state_e;

    typedef struct packed {
        logic [1:0] el;
        logic       secure;
        logic       top_present;
        logic       mon_dis;
        logic       hyp_tsc;
        logic       conduit_smc;
        logic       fw_call_ok;
        logic       top_is64;
    } smc_ctx_t;

endpackage

// File: rtl/smc_route_decide.sv
module smc_route_decide
    import smc_route_pkg::*;
#(
    parameter int EL_W  = 2,
    parameter int SYN_W = 32
) (
    input  smc_ctx_t         ctx_i,
    input  logic [SYN_W-1:0] syn_i,
    output smc_outcome_e     outcome_o,
    output logic [EL_W-1:0]  target_o,
    output logic [SYN_W-1:0] syn_o
);
    localparam logic [EL_W-1:0] LVL1 = EL_W'(1);
    localparam logic [EL_W-1:0] LVL2 = EL_W'(2);
    localparam logic [EL_W-1:0] LVL3 = EL_W'(3);

    logic dis_eff;
    logic no_top_forced;
    logic hyp_trap;
    logic fw_valid;
    logic [EL_W-1:0] undef_tgt;

    always_comb begin
        dis_eff       = ctx_i.mon_dis && (ctx_i.top_is64 || !ctx_i.secure);
        no_top_forced = !ctx_i.top_present && !ctx_i.conduit_smc;
        hyp_trap      = (ctx_i.el == 2'd1) && ctx_i.hyp_tsc;
        fw_valid      = ctx_i.conduit_smc && ctx_i.fw_call_ok;
        undef_tgt     = (ctx_i.secure && !ctx_i.top_is64) ? LVL3 : LVL1;
    end

    always_comb begin
        outcome_o = OUT_UNDEF;
        target_o  = undef_tgt;
        syn_o     = '0;
        if (no_top_forced) begin
            outcome_o = OUT_UNDEF;
            target_o  = undef_tgt;
        end else if (hyp_trap) begin
            outcome_o = OUT_HYP;
            target_o  = LVL2;
            syn_o     = syn_i;
        end else if (fw_valid) begin
            outcome_o = OUT_FW;
            target_o  = LVL3;
        end else if (dis_eff || !ctx_i.top_present) begin
            outcome_o = OUT_UNDEF;
            target_o  = undef_tgt;
        end else begin
            outcome_o = OUT_MON;
            target_o  = LVL3;
        end
    end

endmodule

// File: rtl/smc_route_seq.sv
module smc_route_seq
    import smc_route_pkg::*;
#(
    parameter int EL_W  = 2,
    parameter int SYN_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_i,
    input  smc_outcome_e     dec_outcome_i,
    input  logic [EL_W-1:0]  dec_target_i,
    input  logic [SYN_W-1:0] dec_syn_i,
    output logic             done_o,
    output smc_outcome_e     outcome_o,
    output logic [EL_W-1:0]  target_o,
    output logic [SYN_W-1:0] syn_o
);
    smc_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req_i) state_d = ST_RESP;
            ST_RESP: state_d = req_i ? ST_RESP : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            outcome_o <= OUT_UNDEF;
            target_o  <= '0;
            syn_o     <= '0;
        end else if (req_i) begin
            outcome_o <= dec_outcome_i;
            target_o  <= dec_target_i;
            syn_o     <= dec_syn_i;
        end
    end

    assign done_o = (state_q == ST_RESP);

    assert_done_follows_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
        req_i |=> done_o);
    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !req_i |=> !done_o);
    assert_result_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !req_i |=> ($stable(outcome_o) && $stable(target_o) && $stable(syn_o)));
    assert_target_nonzero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (target_o != '0));

endmodule

// File: rtl/smc_route_top.sv
module smc_route_top
    import smc_route_pkg::*;
#(
    parameter int SYN_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_i,
    input  logic [1:0]       cur_el_i,
    input  logic             secure_i,
    input  logic             top_present_i,
    input  logic             mon_dis_i,
    input  logic             hyp_tsc_i,
    input  logic             conduit_smc_i,
    input  logic             fw_call_ok_i,
    input  logic             top_is64_i,
    input  logic [SYN_W-1:0] syndrome_i,
    output logic             done_o,
    output logic [1:0]       outcome_o,
    output logic [1:0]       target_el_o,
    output logic [SYN_W-1:0] syndrome_o
);
    localparam int EL_W = 2;

    smc_ctx_t         ctx;
    smc_outcome_e     dec_outcome, reg_outcome;
    logic [EL_W-1:0]  dec_target;
    logic [SYN_W-1:0] dec_syn;

    always_comb begin
        ctx.el          = cur_el_i;
        ctx.secure      = secure_i;
        ctx.top_present = top_present_i;
        ctx.mon_dis     = mon_dis_i;
        ctx.hyp_tsc     = hyp_tsc_i;
        ctx.conduit_smc = conduit_smc_i;
        ctx.fw_call_ok  = fw_call_ok_i;
        ctx.top_is64    = top_is64_i;
    end

    smc_route_decide #(.EL_W(EL_W), .SYN_W(SYN_W)) u_decide (
        .ctx_i     (ctx),
        .syn_i     (syndrome_i),
        .outcome_o (dec_outcome),
        .target_o  (dec_target),
        .syn_o     (dec_syn)
    );

    smc_route_seq #(.EL_W(EL_W), .SYN_W(SYN_W)) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_i         (req_i),
        .dec_outcome_i (dec_outcome),
        .dec_target_i  (dec_target),
        .dec_syn_i     (dec_syn),
        .done_o        (done_o),
        .outcome_o     (reg_outcome),
        .target_o      (target_el_o),
        .syn_o         (syndrome_o)
    );

    assign outcome_o = reg_outcome;

    assert_no_top_undef_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && !top_present_i && !conduit_smc_i) |=> (outcome_o == 2'd1));
    assert_hyp_trap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && cur_el_i == 2'd1 && hyp_tsc_i && (top_present_i || conduit_smc_i))
        |=> (outcome_o == 2'd0 && target_el_o == 2'd2 && syndrome_o == $past(syndrome_i)));
    assert_fw_call_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && !(cur_el_i == 2'd1 && hyp_tsc_i) && conduit_smc_i && fw_call_ok_i)
        |=> (outcome_o == 2'd3 && target_el_o == 2'd3));
    assert_mon_trap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && top_present_i && !(cur_el_i == 2'd1 && hyp_tsc_i)
         && !(conduit_smc_i && fw_call_ok_i) && !mon_dis_i)
        |=> (outcome_o == 2'd2 && target_el_o == 2'd3 && syndrome_o == '0));

endmodule

// File: tb/smc_route_top_bench.sv
module smc_route_top_bench;
    localparam int SYN_W = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req = 1'b0;
    logic [1:0] el = 2'd0;
    logic sec = 1'b0, top = 1'b0, dis = 1'b0, tsc = 1'b0;
    logic cond = 1'b0, ok = 1'b0, t64 = 1'b0;
    logic [SYN_W-1:0] syn = '0;
    logic done;
    logic [1:0] outc, tgt;
    logic [SYN_W-1:0] syn_out;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    smc_route_top #(.SYN_W(SYN_W)) u_smc_route_top (
        .clk(clk), .rst_n(rst_n), .req_i(req), .cur_el_i(el), .secure_i(sec),
        .top_present_i(top), .mon_dis_i(dis), .hyp_tsc_i(tsc),
        .conduit_smc_i(cond), .fw_call_ok_i(ok), .top_is64_i(t64),
        .syndrome_i(syn), .done_o(done), .outcome_o(outc),
        .target_el_o(tgt), .syndrome_o(syn_out)
    );

    task automatic check(input logic ok_c, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok_c) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Priority model from R1..R7: returns {outcome, target}
    function automatic logic [3:0] model(input logic [1:0] e, input logic s, input logic tp,
            input logic d, input logic ts, input logic c, input logic v, input logic w);
        logic eff;
        logic [1:0] ut;
        eff = d && (w || !s);
        ut  = (s && !w) ? 2'd3 : 2'd1;
        if (!tp && !c)                return {2'd1, ut};
        else if (e == 2'd1 && ts)     return {2'd0, 2'd2};
        else if (c && v)              return {2'd3, 2'd3};
        else if (eff || !tp)          return {2'd1, ut};
        else                          return {2'd2, 2'd3};
    endfunction

    task automatic issue(input logic [1:0] e, input logic s, input logic tp, input logic d,
            input logic ts, input logic c, input logic v, input logic w, input logic [SYN_W-1:0] sy);
        @(negedge clk);
        el = e; sec = s; top = tp; dis = d; tsc = ts; cond = c; ok = v; t64 = w; syn = sy;
        req = 1'b1;
        @(negedge clk);
        req = 1'b0;
    endtask

    task automatic expect_res(input string tag, input logic [1:0] eo, input logic [1:0] et,
            input logic [SYN_W-1:0] es);
        check(done == 1'b1, {tag, " done"}, 64'(done), 64'd1);
        check(outc == eo, {tag, " outcome"}, 64'(outc), 64'(eo));
        check(tgt == et, {tag, " target"}, 64'(tgt), 64'(et));
        check(syn_out == es, {tag, " syndrome"}, 64'(syn_out), 64'(es));
    endtask

    task automatic t_reset();
        check(done == 1'b0, "R9 reset done", 64'(done), 64'd0);
        check(outc == 2'd1, "R9 reset outcome", 64'(outc), 64'd1);
        check(tgt == 2'd0, "R9 reset target", 64'(tgt), 64'd0);
        check(syn_out == '0, "R9 reset syndrome", 64'(syn_out), 64'd0);
    endtask

    task automatic t_no_top_forced();
        issue(2'd1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 32'h1234);
        expect_res("R2 no top, non-SMC conduit beats hyp trap", 2'd1, 2'd1, '0);
    endtask

    task automatic t_hyp_priority();
        issue(2'd1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 32'hCAFE_0042);
        expect_res("R3 hyp trap over disable and fw call", 2'd0, 2'd2, 32'hCAFE_0042);
    endtask

    task automatic t_fw_with_disable();
        issue(2'd1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 32'h55);
        expect_res("R4 fw call despite disable", 2'd3, 2'd3, '0);
    endtask

    task automatic t_disable_width();
        issue(2'd1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 32'h1);
        expect_res("R1 secure 64-bit disable effective", 2'd1, 2'd1, '0);
        issue(2'd1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 32'h1);
        expect_res("R1 secure 32-bit disable ignored R6", 2'd2, 2'd3, '0);
        issue(2'd0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 32'h1);
        expect_res("R1 non-secure 32-bit disable effective R5", 2'd1, 2'd1, '0);
    endtask

    task automatic t_no_top_smc_invalid();
        issue(2'd2, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 32'h9);
        expect_res("R5 no top, SMC conduit, invalid call; R7 secure 32-bit target", 2'd1, 2'd3, '0);
    endtask

    task automatic t_done_and_hold();
        issue(2'd2, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 32'h7);
        expect_res("R6 monitor trap", 2'd2, 2'd3, '0);
        el = 2'd1; tsc = 1'b1; top = 1'b1; syn = 32'hFFFF;
        @(negedge clk);
        check(done == 1'b0, "R8 done single cycle", 64'(done), 64'd0);
        check(outc == 2'd2, "R8 outcome held without strobe", 64'(outc), 64'd2);
        check(tgt == 2'd3, "R8 target held without strobe", 64'(tgt), 64'd3);
        // back-to-back strobes
        @(negedge clk);
        el = 2'd1; tsc = 1'b1; syn = 32'hA1; req = 1'b1;
        @(negedge clk);
        expect_res("R8 back-to-back first", 2'd0, 2'd2, 32'hA1);
        tsc = 1'b0; cond = 1'b1; ok = 1'b1;
        @(negedge clk);
        req = 1'b0;
        expect_res("R8 back-to-back second", 2'd3, 2'd3, '0);
        @(negedge clk);
        check(done == 1'b0, "R8 done drops after burst", 64'(done), 64'd0);
    endtask

    task automatic t_sweep();
        for (int i = 0; i < 512; i++) begin
            logic [3:0] m;
            logic [SYN_W-1:0] sy;
            logic [8:0] b;
            b  = 9'(i);
            sy = 32'h1000 + 32'(i);
            m  = model(b[1:0], b[2], b[3], b[4], b[5], b[6], b[7], b[8]);
            issue(b[1:0], b[2], b[3], b[4], b[5], b[6], b[7], b[8], sy);
            expect_res("R1 R5 R6 R7 sweep", m[3:2], m[1:0], (m[3:2] == 2'd0) ? sy : '0);
        end
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_no_top_forced();
        t_hyp_priority();
        t_fw_with_disable();
        t_disable_width();
        t_no_top_smc_invalid();
        t_done_and_hold();
        t_sweep();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule